// File: doc/BRIEF.md
# Load/Store Transfer Sequencer

This block carries out single-word load and store instructions for a 32-bit core with sixteen general registers, where register 15 holds the program counter. Decoded fields arrive with a start strobe. The fields are the direction, the base index, the data register index, a register or immediate offset, pre/post indexing, write-back and add/subtract. The block reads its operands through three combinational register-file read ports and forms the effective address. It then performs one access on a simple single-cycle memory port. Its results leave as a register write, a base-register update, or an abort trap.

Register 15 is not read from the register file when it is the base or the store source. In those cases it shows the instruction address plus a pipeline offset that depends on how it is used. Encodings that cannot be restarted cleanly, or that have no defined meaning, are refused with an illegal flag. Every executed instruction emits a per-cycle trace that marks each clock as sequential, non-sequential or internal. This lets a cycle accounting model follow the cost of each transfer.

Top module: `ldst_seq`

## Requirements
- R1: When the base index is 15, the base operand is the latched instruction address plus 8, and the register file is not used for it.
- R2: A store whose data register is 15 writes the instruction address plus 12 to memory.
- R3: An encoding is illegal when any of these holds: the base is 15 and the transfer writes back (write-back bit set, or post-indexed); a register offset selects register 15; a post-indexed transfer uses a register offset whose index equals the base. An illegal encoding gives one cycle with `illegal` and `done` high, no trace, no memory access and no register writes.
- R4: The offset is the register operand or the zero-extended immediate. It is added when the up bit is 1 and subtracted otherwise. Pre-indexed transfers access base±offset. Post-indexed transfers access the unmodified base. The base register receives base±offset when write-back is set or the transfer is post-indexed.
- R5: If `mem_abort` is high in the memory cycle, `abort_trap` pulses in that cycle. There is no data-register write and no base update, so the base keeps its value from before the instruction. The trace ends with that cycle, and `done` pulses in it.
- R6: `cyc_type` encodes 01 = sequential (S), 10 = non-sequential (N), 11 = internal (I), and 00 while no trace cycle is present. A load traces S, N, I. Memory is read in the N cycle, and the data register is written with the read data in the I cycle.
- R7: A load whose data register is 15 traces S, N, I, S, N. Register 15 is written in the I cycle.
- R8: A store traces N, N. The memory write is issued in the second N cycle.
- R9: `done` is high for exactly one cycle, in the last trace cycle. `busy` is high from the cycle after an accepted start until after `done`. A start seen while busy is ignored.
- R10: While reset is held, `busy`, `done`, `mem_req`, `cyc_valid`, `rd_we`, `base_we`, `illegal` and `abort_trap` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present; taken only when idle |
| op_load | input | 1 | 1 = load, 0 = store |
| op_base | input | 4 | Base register index |
| op_rd | input | 4 | Load destination / store source index |
| op_regofs | input | 1 | 1 = offset from register, 0 = immediate |
| op_rm | input | 4 | Offset register index |
| op_imm | input | 12 | Immediate offset |
| op_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| op_wb | input | 1 | Write-back request |
| op_up | input | 1 | 1 = add offset, 0 = subtract |
| op_pc | input | 32 | Address of the current instruction |
| rf_base_idx | output | 4 | Read port A index (base) |
| rf_base_val | input | 32 | Read port A data |
| rf_ofs_idx | output | 4 | Read port B index (offset) |
| rf_ofs_val | input | 32 | Read port B data |
| rf_src_idx | output | 4 | Read port C index (store data) |
| rf_src_val | input | 32 | Read port C data |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, same cycle |
| mem_abort | input | 1 | Access aborted, same cycle |
| rd_we | output | 1 | Data register write strobe |
| rd_idx | output | 4 | Data register index |
| rd_data | output | 32 | Data register value |
| base_we | output | 1 | Base update strobe |
| base_idx | output | 4 | Base register index |
| base_data | output | 32 | Updated base value |
| illegal | output | 1 | Refused encoding |
| abort_trap | output | 1 | Data abort trap request |
| cyc_valid | output | 1 | Trace cycle present |
| cyc_type | output | 2 | Trace cycle type |
| done | output | 1 | Instruction finished |
| busy | output | 1 | Instruction in progress |

## Verification
The hardest case to reach is a cycle with several effects at once, where an abort arrives in the same memory cycle that would otherwise commit a base update. That cycle is the only one where the early-abort restore rule can be seen. The stimulus table drives `mem_abort` from a per-vector flag gated by `mem_req`, so the abort lands exactly in the access cycle. The flag is set on a pre-indexed write-back load, on a post-indexed store and on a load into register 15. The bench then confirms that the trace was cut short and that neither write strobe fired. A second hard case is a start presented mid-instruction. A directed test holds start high with store fields during a running load and checks that no write access and no extra trace cycle appear.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int unsigned LS_DW    = 32;
  localparam int unsigned LS_RIW   = 4;
  localparam int unsigned LS_IMMW  = 12;
  localparam logic [LS_RIW-1:0] LS_PC_IDX = '1;
  localparam int unsigned LS_BASE_PCOFS  = 8;
  localparam int unsigned LS_STORE_PCOFS = 12;

  typedef enum logic [1:0] {
    CT_NONE = 2'b00,
    CT_SEQ  = 2'b01,
    CT_NSEQ = 2'b10,
    CT_INT  = 2'b11
  } cyc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ILL,
    ST_ADDR,
    ST_MEM,
    ST_INT,
    ST_RFS,
    ST_RFN
  } st_t;

  function automatic logic [LS_DW-1:0] pc_view(input logic [LS_DW-1:0] pc,
                                               input int unsigned ofs);
    return pc + LS_DW'(ofs);
  endfunction

  function automatic logic [LS_DW-1:0] ofs_apply(input logic [LS_DW-1:0] base,
                                                 input logic [LS_DW-1:0] ofs,
                                                 input logic up);
    return up ? (base + ofs) : (base - ofs);
  endfunction

  function automatic logic enc_illegal(input logic [LS_RIW-1:0] base,
                                       input logic [LS_RIW-1:0] rm,
                                       input logic regofs,
                                       input logic pre,
                                       input logic wb);
    logic pc_wb, pc_ofs, post_alias;
    pc_wb      = (base == LS_PC_IDX) && (wb || !pre);
    pc_ofs     = regofs && (rm == LS_PC_IDX);
    post_alias = regofs && !pre && (rm == base);
    return pc_wb || pc_ofs || post_alias;
  endfunction

endpackage

// File: rtl/ldst_addr.sv
module ldst_addr
  import ldst_pkg::*;
#(
  parameter int unsigned DW   = LS_DW,
  parameter int unsigned RIW  = LS_RIW,
  parameter int unsigned IMMW = LS_IMMW
) (
  input  logic [RIW-1:0]  base_idx,
  input  logic [RIW-1:0]  src_idx,
  input  logic            regofs,
  input  logic [IMMW-1:0] imm,
  input  logic            pre,
  input  logic            up,
  input  logic [DW-1:0]   pc,
  input  logic [DW-1:0]   base_rf,
  input  logic [DW-1:0]   ofs_rf,
  input  logic [DW-1:0]   src_rf,
  output logic [DW-1:0]   ea,
  output logic [DW-1:0]   upd,
  output logic [DW-1:0]   sdata
);

  logic [DW-1:0] base_v;
  logic [DW-1:0] ofs_v;

  always_comb begin
    base_v = (base_idx == RIW'(LS_PC_IDX)) ? pc_view(pc, LS_BASE_PCOFS) : base_rf;
    ofs_v  = regofs ? ofs_rf : DW'(imm);
    upd    = ofs_apply(base_v, ofs_v, up);
    ea     = pre ? upd : base_v;
    sdata  = (src_idx == RIW'(LS_PC_IDX)) ? pc_view(pc, LS_STORE_PCOFS) : src_rf;
  end

endmodule

// File: rtl/ldst_fsm.sv
module ldst_fsm
  import ldst_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  logic   bad_enc,
  input  logic   is_load,
  input  logic   rd_is_pc,
  input  logic   abort_in,
  output st_t    state,
  output logic   ev_mem,
  output logic   ev_abort,
  output logic   ev_last,
  output logic   cyc_valid,
  output cyc_t   cyc_type
);

  st_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (take) nxt = bad_enc ? ST_ILL : ST_ADDR;
      ST_ILL:  nxt = ST_IDLE;
      ST_ADDR: nxt = ST_MEM;
      ST_MEM:  nxt = (abort_in || !is_load) ? ST_IDLE : ST_INT;
      ST_INT:  nxt = rd_is_pc ? ST_RFS : ST_IDLE;
      ST_RFS:  nxt = ST_RFN;
      ST_RFN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    ev_mem   = (state == ST_MEM);
    ev_abort = ev_mem && abort_in;
    ev_last  = (state == ST_ILL) ||
               (ev_mem && (abort_in || !is_load)) ||
               ((state == ST_INT) && !rd_is_pc) ||
               (state == ST_RFN);
    cyc_valid = 1'b1;
    unique case (state)
      ST_ADDR: cyc_type = is_load ? CT_SEQ : CT_NSEQ;
      ST_MEM:  cyc_type = CT_NSEQ;
      ST_INT:  cyc_type = CT_INT;
      ST_RFS:  cyc_type = CT_SEQ;
      ST_RFN:  cyc_type = CT_NSEQ;
      default: begin
        cyc_type  = CT_NONE;
        cyc_valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ldst_seq.sv
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int unsigned DW   = LS_DW,
  parameter int unsigned RIW  = LS_RIW,
  parameter int unsigned IMMW = LS_IMMW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_load,
  input  logic [RIW-1:0]  op_base,
  input  logic [RIW-1:0]  op_rd,
  input  logic            op_regofs,
  input  logic [RIW-1:0]  op_rm,
  input  logic [IMMW-1:0] op_imm,
  input  logic            op_pre,
  input  logic            op_wb,
  input  logic            op_up,
  input  logic [DW-1:0]   op_pc,
  output logic [RIW-1:0]  rf_base_idx,
  input  logic [DW-1:0]   rf_base_val,
  output logic [RIW-1:0]  rf_ofs_idx,
  input  logic [DW-1:0]   rf_ofs_val,
  output logic [RIW-1:0]  rf_src_idx,
  input  logic [DW-1:0]   rf_src_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_abort,
  output logic            rd_we,
  output logic [RIW-1:0]  rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic            base_we,
  output logic [RIW-1:0]  base_idx,
  output logic [DW-1:0]   base_data,
  output logic            illegal,
  output logic            abort_trap,
  output logic            cyc_valid,
  output logic [1:0]      cyc_type,
  output logic            done,
  output logic            busy
);

  // latched instruction
  logic            q_load, q_regofs, q_pre, q_wb, q_up;
  logic [RIW-1:0]  q_base, q_rd, q_rm;
  logic [IMMW-1:0] q_imm;
  logic [DW-1:0]   q_pc;

  // computed values
  logic [DW-1:0] ea_w, upd_w, sdata_w;
  logic [DW-1:0] ea_q, upd_q, sdata_q, ldata_q;

  // named internal events
  st_t  state;
  logic ev_take, ev_bad, ev_mem, ev_abort, ev_last, ev_addr;
  cyc_t ctype;

  assign ev_take = start && (state == ST_IDLE);
  assign ev_bad  = enc_illegal(op_base, op_rm, op_regofs, op_pre, op_wb);
  assign ev_addr = (state == ST_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_load <= 1'b0; q_regofs <= 1'b0; q_pre <= 1'b0; q_wb <= 1'b0; q_up <= 1'b0;
      q_base <= '0; q_rd <= '0; q_rm <= '0; q_imm <= '0; q_pc <= '0;
    end else if (ev_take) begin
      q_load <= op_load; q_regofs <= op_regofs; q_pre <= op_pre;
      q_wb <= op_wb; q_up <= op_up;
      q_base <= op_base; q_rd <= op_rd; q_rm <= op_rm;
      q_imm <= op_imm; q_pc <= op_pc;
    end
  end

  assign rf_base_idx = q_base;
  assign rf_ofs_idx  = q_rm;
  assign rf_src_idx  = q_rd;

  ldst_addr #(.DW(DW), .RIW(RIW), .IMMW(IMMW)) addr_i (
    .base_idx (q_base),
    .src_idx  (q_rd),
    .regofs   (q_regofs),
    .imm      (q_imm),
    .pre      (q_pre),
    .up       (q_up),
    .pc       (q_pc),
    .base_rf  (rf_base_val),
    .ofs_rf   (rf_ofs_val),
    .src_rf   (rf_src_val),
    .ea       (ea_w),
    .upd      (upd_w),
    .sdata    (sdata_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_q <= '0; upd_q <= '0; sdata_q <= '0; ldata_q <= '0;
    end else begin
      if (ev_addr) begin
        ea_q    <= ea_w;
        upd_q   <= upd_w;
        sdata_q <= sdata_w;
      end
      if (ev_mem && q_load) ldata_q <= mem_rdata;
    end
  end

  ldst_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (ev_take),
    .bad_enc   (ev_bad),
    .is_load   (q_load),
    .rd_is_pc  (q_rd == RIW'(LS_PC_IDX)),
    .abort_in  (mem_abort),
    .state     (state),
    .ev_mem    (ev_mem),
    .ev_abort  (ev_abort),
    .ev_last   (ev_last),
    .cyc_valid (cyc_valid),
    .cyc_type  (ctype)
  );

  assign cyc_type   = ctype;
  assign mem_req    = ev_mem;
  assign mem_we     = ev_mem && !q_load;
  assign mem_addr   = ea_q;
  assign mem_wdata  = sdata_q;
  assign abort_trap = ev_abort;
  assign base_we    = ev_mem && !mem_abort && (q_wb || !q_pre);
  assign base_idx   = q_base;
  assign base_data  = upd_q;
  assign rd_we      = (state == ST_INT);
  assign rd_idx     = q_rd;
  assign rd_data    = ldata_q;
  assign illegal    = (state == ST_ILL);
  assign done       = ev_last;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/ldst_seq_chk.sv
module ldst_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic       abort_trap,
  input logic       cyc_valid,
  input logic [1:0] cyc_type,
  input logic       mem_req,
  input logic       rd_we,
  input logic       base_we,
  input logic [3:0] base_idx
);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_trace_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_valid || illegal));

  assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_mem_in_ncycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (cyc_valid && cyc_type == 2'b10));

  assert_rdwe_in_icycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (cyc_type == 2'b11));

  assert_abort_no_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_trap |-> (!rd_we && !base_we && done));

  assert_abort_in_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_trap |-> mem_req);

  assert_no_pc_base_upd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> (base_idx != 4'hF));

  assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_req && !cyc_valid && !rd_we && !base_we && done));

  assert_trace_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_type != 2'b00));

endmodule

bind ldst_seq ldst_seq_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .illegal    (illegal),
  .abort_trap (abort_trap),
  .cyc_valid  (cyc_valid),
  .cyc_type   (cyc_type),
  .mem_req    (mem_req),
  .rd_we      (rd_we),
  .base_we    (base_we),
  .base_idx   (base_idx)
);

// File: tb/ldst_seq_tb_top.sv
module ldst_seq_tb_top;

  localparam logic [31:0] PC0  = 32'h0000_8000;
  localparam logic [31:0] RKEY = 32'h5A5A_0000;

  typedef struct packed {
    logic        ld;
    logic [3:0]  base;
    logic [3:0]  rd;
    logic        ureg;
    logic [3:0]  rm;
    logic [11:0] imm;
    logic        pre;
    logic        wb;
    logic        up;
    logic        ab;
    logic [9:0]  trace;
    logic [2:0]  len;
    logic        ill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1,4'd2, 4'd3, 1'b0,4'd0, 12'h010,1'b1,1'b0,1'b1,1'b0,10'h039,3'd3,1'b0},
    '{1'b1,4'd4, 4'd5, 1'b1,4'd6, 12'h000,1'b0,1'b0,1'b0,1'b0,10'h039,3'd3,1'b0},
    '{1'b1,4'd1, 4'd15,1'b0,4'd0, 12'h004,1'b1,1'b1,1'b1,1'b0,10'h279,3'd5,1'b0},
    '{1'b0,4'd7, 4'd8, 1'b1,4'd9, 12'h000,1'b1,1'b1,1'b1,1'b0,10'h00A,3'd2,1'b0},
    '{1'b0,4'd2, 4'd15,1'b0,4'd0, 12'h000,1'b1,1'b0,1'b1,1'b0,10'h00A,3'd2,1'b0},
    '{1'b1,4'd15,4'd0, 1'b0,4'd0, 12'h020,1'b1,1'b0,1'b1,1'b0,10'h039,3'd3,1'b0},
    '{1'b1,4'd3, 4'd4, 1'b0,4'd0, 12'h008,1'b1,1'b1,1'b1,1'b1,10'h009,3'd2,1'b0},
    '{1'b0,4'd6, 4'd2, 1'b0,4'd0, 12'h040,1'b0,1'b0,1'b0,1'b1,10'h00A,3'd2,1'b0},
    '{1'b1,4'd15,4'd1, 1'b0,4'd0, 12'h000,1'b1,1'b1,1'b1,1'b0,10'h000,3'd0,1'b1},
    '{1'b0,4'd2, 4'd3, 1'b1,4'd15,12'h000,1'b1,1'b0,1'b1,1'b0,10'h000,3'd0,1'b1},
    '{1'b1,4'd5, 4'd6, 1'b1,4'd5, 12'h000,1'b0,1'b0,1'b1,1'b0,10'h000,3'd0,1'b1},
    '{1'b1,4'd5, 4'd6, 1'b1,4'd5, 12'h000,1'b1,1'b1,1'b0,1'b0,10'h039,3'd3,1'b0},
    '{1'b1,4'd1, 4'd15,1'b0,4'd0, 12'h000,1'b1,1'b0,1'b1,1'b1,10'h009,3'd2,1'b0},
    '{1'b1,4'd15,4'd2, 1'b0,4'd0, 12'h004,1'b0,1'b0,1'b1,1'b0,10'h000,3'd0,1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0, op_load = 1'b0, op_regofs = 1'b0;
  logic        op_pre = 1'b0, op_wb = 1'b0, op_up = 1'b0;
  logic [3:0]  op_base = '0, op_rd = '0, op_rm = '0;
  logic [11:0] op_imm = '0;
  logic [31:0] op_pc = PC0;
  logic [3:0]  rf_base_idx, rf_ofs_idx, rf_src_idx;
  logic [31:0] rf_base_val, rf_ofs_val, rf_src_val;
  logic        mem_req, mem_we, mem_abort;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        rd_we, base_we, illegal, abort_trap, cyc_valid, done, busy;
  logic [3:0]  rd_idx, base_idx;
  logic [31:0] rd_data, base_data;
  logic [1:0]  cyc_type;
  logic        cur_ab = 1'b0;
  logic        rf_init = 1'b0;
  logic [31:0] rf [16];

  function automatic logic [31:0] init_val(input logic [3:0] i);
    return 32'h0001_0000 + {20'd0, i, 8'd0};
  endfunction

  always @(posedge clk) begin
    if (rf_init) begin
      for (int i = 0; i < 16; i++) rf[i] <= init_val(4'(i));
    end else begin
      if (base_we) rf[base_idx] <= base_data;
      if (rd_we)   rf[rd_idx]   <= rd_data;
    end
  end

  assign rf_base_val = rf[rf_base_idx];
  assign rf_ofs_val  = rf[rf_ofs_idx];
  assign rf_src_val  = rf[rf_src_idx];
  assign mem_rdata   = mem_addr ^ RKEY;
  assign mem_abort   = mem_req && cur_ab;

  ldst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_load(op_load),
    .op_base(op_base), .op_rd(op_rd), .op_regofs(op_regofs), .op_rm(op_rm),
    .op_imm(op_imm), .op_pre(op_pre), .op_wb(op_wb), .op_up(op_up), .op_pc(op_pc),
    .rf_base_idx(rf_base_idx), .rf_base_val(rf_base_val),
    .rf_ofs_idx(rf_ofs_idx), .rf_ofs_val(rf_ofs_val),
    .rf_src_idx(rf_src_idx), .rf_src_val(rf_src_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_abort(mem_abort),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
    .base_we(base_we), .base_idx(base_idx), .base_data(base_data),
    .illegal(illegal), .abort_trap(abort_trap), .cyc_valid(cyc_valid),
    .cyc_type(cyc_type), .done(done), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc_cnt);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  // observed results of one instruction
  logic [9:0]  s_trace;
  int          s_len, s_done, s_req;
  logic        s_ill, s_trap, s_rdw, s_bw, s_we;
  logic [31:0] s_addr, s_wdata, s_rdd, s_bd;
  logic [3:0]  s_rdi, s_bi;

  task automatic run_one(input vec_t v, input logic mid_start);
    s_trace = '0; s_len = 0; s_done = 0; s_req = 0;
    s_ill = 0; s_trap = 0; s_rdw = 0; s_bw = 0; s_we = 0;
    s_addr = '0; s_wdata = '0; s_rdd = '0; s_bd = '0; s_rdi = '0; s_bi = '0;
    @(negedge clk); rf_init = 1'b1;
    @(negedge clk); rf_init = 1'b0;
    op_load = v.ld; op_base = v.base; op_rd = v.rd; op_regofs = v.ureg;
    op_rm = v.rm; op_imm = v.imm; op_pre = v.pre; op_wb = v.wb; op_up = v.up;
    cur_ab = v.ab; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 16; c++) begin
      if (cyc_valid) begin
        s_trace = s_trace | (10'(cyc_type) << (2 * s_len));
        s_len++;
      end
      if (mem_req) begin s_req++; s_addr = mem_addr; s_wdata = mem_wdata; s_we = s_we | mem_we; end
      if (rd_we)   begin s_rdw = 1; s_rdi = rd_idx; s_rdd = rd_data; end
      if (base_we) begin s_bw = 1; s_bi = base_idx; s_bd = base_data; end
      if (illegal)    s_ill = 1;
      if (abort_trap) s_trap = 1;
      if (done) s_done++;
      if (mid_start && c == 0) begin
        start = 1'b1; op_load = 1'b0; op_base = 4'd9; op_pre = 1'b0;
      end
      if (mid_start && c == 2) start = 1'b0;
      if (done && !mid_start) break;
      if (done && mid_start && c >= 2) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic check_vec(input vec_t v, input int k);
    logic [31:0] bv, ov, s, ea, sd;
    logic        upd, ldw;
    string       tag;
    tag = $sformatf("vec%0d", k);
    bv  = (v.base == 4'd15) ? PC0 + 32'd8 : init_val(v.base);
    ov  = v.ureg ? init_val(v.rm) : {20'd0, v.imm};
    s   = v.up ? bv + ov : bv - ov;
    ea  = v.pre ? s : bv;
    sd  = (v.rd == 4'd15) ? PC0 + 32'd12 : init_val(v.rd);
    upd = (v.wb || !v.pre) && !v.ab && !v.ill;
    ldw = v.ld && !v.ab && !v.ill;

    chk(s_len == int'(v.len), v.rd == 4'd15 && v.ld ? "R7" : (v.ld ? "R6" : "R8"),
        {tag, " trace length"}, 32'(s_len), 32'(v.len));
    chk(s_trace == v.trace, v.ld ? "R6" : "R8", {tag, " trace"}, 32'(s_trace), 32'(v.trace));
    chk(s_done == 1, "R9", {tag, " done pulses"}, 32'(s_done), 32'd1);
    chk(s_ill == v.ill, "R3", {tag, " illegal"}, 32'(s_ill), 32'(v.ill));
    chk(s_trap == v.ab, "R5", {tag, " abort trap"}, 32'(s_trap), 32'(v.ab));
    if (v.ill) begin
      chk(s_req == 0 && !s_rdw && !s_bw, "R3", {tag, " no side effects"},
          {29'd0, s_req != 0, s_rdw, s_bw}, 32'd0);
    end else begin
      chk(s_req == 1, "R4", {tag, " access count"}, 32'(s_req), 32'd1);
      chk(s_addr == ea, v.base == 4'd15 ? "R1" : "R4", {tag, " address"}, s_addr, ea);
      chk(s_we == !v.ld, "R8", {tag, " direction"}, 32'(s_we), 32'(!v.ld));
      if (!v.ld) chk(s_wdata == sd, v.rd == 4'd15 ? "R2" : "R8", {tag, " store data"}, s_wdata, sd);
      chk(s_bw == upd, v.ab ? "R5" : "R4", {tag, " base update"}, 32'(s_bw), 32'(upd));
      if (upd) chk(s_bd == s && s_bi == v.base, "R4", {tag, " base value"}, s_bd, s);
      chk(s_rdw == ldw, v.ab ? "R5" : "R6", {tag, " rd write"}, 32'(s_rdw), 32'(ldw));
      if (ldw) chk(s_rdd == (ea ^ RKEY) && s_rdi == v.rd, v.rd == 4'd15 ? "R7" : "R6",
                   {tag, " rd data"}, s_rdd, ea ^ RKEY);
    end
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !cyc_valid, "R10", "idle strobes in reset",
        {28'd0, busy, done, mem_req, cyc_valid}, 32'd0);
    chk(!rd_we && !base_we && !illegal && !abort_trap, "R10", "write strobes in reset",
        {28'd0, rd_we, base_we, illegal, abort_trap}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cyc_type == 2'b00, "R10", "idle after reset",
        {29'd0, busy, cyc_type}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      run_one(VEC[k], 1'b0);
      check_vec(VEC[k], k);
    end

    // R9: start held during a running load is ignored
    run_one(VEC[0], 1'b1);
    chk(s_len == 3 && s_trace == 10'h039, "R9", "trace with start while busy",
        32'(s_trace), 32'h039);
    chk(!s_we && s_req == 1, "R9", "no extra access while busy", 32'(s_req), 32'd1);
    chk(s_done == 1, "R9", "single done while busy", 32'(s_done), 32'd1);
    chk(!busy, "R9", "idle after ignored start", 32'(busy), 32'd0);

    // R10: reset mid-instruction returns to idle
    @(negedge clk); rf_init = 1'b1;
    @(negedge clk); rf_init = 1'b0;
    op_load = 1'b1; op_base = 4'd2; op_rd = 4'd3; op_regofs = 1'b0; op_pre = 1'b1;
    op_wb = 1'b0; op_imm = 12'h0; cur_ab = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !cyc_valid && !mem_req, "R10", "reset during instruction",
        {29'd0, busy, cyc_valid, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule